// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block keeps the architectural floating-point status word beside an arithmetic unit. When an operation completes, the arithmetic unit raises a completion strobe and reports five raw IEEE flags. The block turns those flags into a current-exception vector and compares it with a per-exception trap-enable mask. An enabled exception sets the trap-type field and requests a trap. A masked exception is added to the sticky accrued field and clears the trap type.

The stored rounding-direction field is decoded into a one-hot mode that goes to the datapath. Software reaches the status word through one combinational read path and three write flavours. The full write loads every stored field. The second write keeps the condition codes. The third keeps both the condition codes and the trap type. A read-only version number is merged into every read.

Word layout (read and write): current exceptions [4:0], accrued [9:5], condition codes [11:10], trap type [16:14], version [19:17], trap-enable mask [27:23], rounding [31:30]. All other bits read as zero. Each 5-bit exception field orders its bits the same way: invalid in bit 4, overflow in bit 3, underflow in bit 2, divide-by-zero in bit 1, inexact in bit 0.

Top module: `fpu_exc_unit`

## Requirements
- R1: After reset, every stored field is zero and the rounding mode is nearest-even. The trap request is low, and a read returns only the version field.
- R2: On a completion, the current-exception field [4:0] is loaded from the flags: invalid to bit 4, overflow to bit 3, underflow to bit 2, divide-by-zero to bit 1, inexact to bit 0.
- R3: If a completion's exception vector ANDed with the trap-enable mask [27:23] is nonzero, the trap type [16:14] becomes 1. trap_req_o is then high for exactly the following cycle.
- R4: A trapping completion leaves the accrued field [9:5] unchanged.
- R5: A non-trapping completion ORs the exception vector into the accrued field and sets the trap type to 0.
- R6: While op_done_i is low and no write is requested, the flags are ignored and the read word does not change.
- R7: round_mode_o is one-hot, decoded from bits [31:30]: 0 gives 4'b0001 (nearest-even), 1 gives 4'b0010 (toward zero), 2 gives 4'b0100 (toward +infinity), 3 gives 4'b1000 (toward -infinity).
- R8: wr_kind_i = 1 (full write) loads the current, accrued, condition-code, trap-type, trap-enable and rounding fields from wr_data_i.
- R9: wr_kind_i = 2 loads the same fields as R8 except the condition codes, which keep their value.
- R10: wr_kind_i = 3 loads the current, accrued, trap-enable and rounding fields and keeps both the condition codes and the trap type.
- R11: rd_data_o always carries the VERSION_ID parameter in bits [19:17], whatever was written there. All unassigned bits read as zero.
- R12: When a write and a completion arrive in the same cycle, the write takes effect, the flags are dropped and no trap is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_done_i | input | 1 | Operation completion strobe |
| flag_invalid_i | input | 1 | Raw invalid-operation flag |
| flag_overflow_i | input | 1 | Raw overflow flag |
| flag_underflow_i | input | 1 | Raw underflow flag |
| flag_divzero_i | input | 1 | Raw divide-by-zero flag |
| flag_inexact_i | input | 1 | Raw inexact flag |
| wr_kind_i | input | 2 | 0 none, 1 full write, 2 keep condition codes, 3 keep condition codes and trap type |
| wr_data_i | input | 32 | Word to write |
| rd_data_o | output | 32 | Status word read-back, version merged |
| round_mode_o | output | 4 | One-hot rounding mode for the datapath |
| trap_req_o | output | 1 | One-cycle trap request |

## Verification
The assertions assume that the flags mean something only while the completion strobe is high, and that any two-bit value on the write selector is legal, so a write can land on the same edge as a completion. The assertions also assume that the inputs settle well before each rising edge. The stimulus changes every input on the falling edge. It mixes directed sequences with random traffic that sets flags while the strobe is low, collides writes with completions, and reprograms the trap-enable mask often enough that both the trapping and the accumulating paths are exercised.

// File: rtl/fpu_exc_pkg.sv
package fpu_exc_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned EXC_W   = 5;
  localparam int unsigned FCC_W   = 2;
  localparam int unsigned FTT_W   = 3;
  localparam int unsigned VER_W   = 3;
  localparam int unsigned RND_W   = 2;

  localparam int unsigned CEXC_LSB = 0;
  localparam int unsigned AEXC_LSB = 5;
  localparam int unsigned FCC_LSB  = 10;
  localparam int unsigned FTT_LSB  = 14;
  localparam int unsigned VER_LSB  = 17;
  localparam int unsigned TEM_LSB  = 23;
  localparam int unsigned RND_LSB  = 30;

  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_FULL  = 2'd1,
    WR_NO_CC = 2'd2,
    WR_PART  = 2'd3
  } wr_kind_e;

  typedef struct packed {
    logic [RND_W-1:0] rnd;
    logic [EXC_W-1:0] tem;
    logic [FTT_W-1:0] ftt;
    logic [FCC_W-1:0] fcc;
    logic [EXC_W-1:0] aexc;
    logic [EXC_W-1:0] cexc;
  } fsr_t;

  function automatic fsr_t word_to_fsr(input logic [WORD_W-1:0] w);
    fsr_t r;
    r.cexc = w[CEXC_LSB +: EXC_W];
    r.aexc = w[AEXC_LSB +: EXC_W];
    r.fcc  = w[FCC_LSB  +: FCC_W];
    r.ftt  = w[FTT_LSB  +: FTT_W];
    r.tem  = w[TEM_LSB  +: EXC_W];
    r.rnd  = w[RND_LSB  +: RND_W];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] fsr_to_word(input fsr_t s,
                                                    input logic [VER_W-1:0] ver);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CEXC_LSB +: EXC_W] = s.cexc;
    w[AEXC_LSB +: EXC_W] = s.aexc;
    w[FCC_LSB  +: FCC_W] = s.fcc;
    w[FTT_LSB  +: FTT_W] = s.ftt;
    w[VER_LSB  +: VER_W] = ver;
    w[TEM_LSB  +: EXC_W] = s.tem;
    w[RND_LSB  +: RND_W] = s.rnd;
    return w;
  endfunction
endpackage

// File: rtl/fpu_exc_classify.sv
module fpu_exc_classify
  import fpu_exc_pkg::*;
(
  input  logic             done_i,
  input  logic [EXC_W-1:0] flags_i,
  input  logic [EXC_W-1:0] tem_i,
  output logic [EXC_W-1:0] cexc_o,
  output logic             hit_o
);
  logic [EXC_W-1:0] enabled;

  for (genvar i = 0; i < EXC_W; i++) begin : g_bit
    assign cexc_o[i]  = done_i & flags_i[i];
    assign enabled[i] = cexc_o[i] & tem_i[i];
  end

  assign hit_o = |enabled;
endmodule

// File: rtl/fpu_exc_round_dec.sv
module fpu_exc_round_dec #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned N    = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     mode_o
);
  for (genvar i = 0; i < N; i++) begin : g_mode
    assign mode_o[i] = (sel_i == SEL_W'(i));
  end

  assert_round_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(mode_o));
endmodule

// File: rtl/fpu_exc_state.sv
module fpu_exc_state
  import fpu_exc_pkg::*;
#(
  parameter logic [FTT_W-1:0] TRAP_CODE = 3'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [EXC_W-1:0]  cexc_i,
  input  logic              hit_i,
  input  wr_kind_e          wr_kind_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output fsr_t              st_o,
  output logic              trap_o
);
  fsr_t st_q, st_d, wr_st;
  logic trap_q, trap_d;

  always_comb begin
    st_d   = st_q;
    trap_d = 1'b0;
    wr_st  = word_to_fsr(wr_data_i);
    unique case (wr_kind_i)
      WR_FULL:  st_d = wr_st;
      WR_NO_CC: begin
        st_d     = wr_st;
        st_d.fcc = st_q.fcc;
      end
      WR_PART: begin
        st_d     = wr_st;
        st_d.fcc = st_q.fcc;
        st_d.ftt = st_q.ftt;
      end
      default: begin
        if (done_i) begin
          st_d.cexc = cexc_i;
          if (hit_i) begin
            st_d.ftt = TRAP_CODE;
            trap_d   = 1'b1;
          end else begin
            st_d.aexc = st_q.aexc | cexc_i;
            st_d.ftt  = '0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      trap_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      trap_q <= trap_d;
    end
  end

  assign st_o   = st_q;
  assign trap_o = trap_q;

  assert_trap_sets_type_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q |-> (st_q.ftt == TRAP_CODE));

  assert_trap_keeps_accrued_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q |-> $stable(st_q.aexc));

  assert_masked_accumulates_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && wr_kind_i == WR_NONE && !hit_i) |=>
      (((st_q.aexc & $past(cexc_i)) == $past(cexc_i)) && st_q.ftt == '0 && !trap_q));

  assert_idle_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && wr_kind_i == WR_NONE) |=> ($stable(st_q) && !trap_q));

  assert_part_keeps_type_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind_i == WR_PART) |=> ($stable(st_q.ftt) && $stable(st_q.fcc)));

  assert_write_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind_i != WR_NONE) |=> !trap_q);
endmodule

// File: rtl/fpu_exc_unit.sv
module fpu_exc_unit
  import fpu_exc_pkg::*;
#(
  parameter logic [VER_W-1:0] VERSION_ID = 3'd5,
  parameter logic [FTT_W-1:0] TRAP_CODE  = 3'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_done_i,
  input  logic              flag_invalid_i,
  input  logic              flag_overflow_i,
  input  logic              flag_underflow_i,
  input  logic              flag_divzero_i,
  input  logic              flag_inexact_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [(1<<RND_W)-1:0] round_mode_o,
  output logic              trap_req_o
);
  logic [EXC_W-1:0] flags, cexc;
  logic             hit;
  fsr_t             st;
  wr_kind_e         wr_kind;

  // invalid is the most significant exception bit
  assign flags   = {flag_invalid_i, flag_overflow_i, flag_underflow_i,
                    flag_divzero_i, flag_inexact_i};
  assign wr_kind = wr_kind_e'(wr_kind_i);

  fpu_exc_classify u_classify (
    .done_i (op_done_i),
    .flags_i(flags),
    .tem_i  (st.tem),
    .cexc_o (cexc),
    .hit_o  (hit)
  );

  fpu_exc_state #(.TRAP_CODE(TRAP_CODE)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (op_done_i),
    .cexc_i   (cexc),
    .hit_i    (hit),
    .wr_kind_i(wr_kind),
    .wr_data_i(wr_data_i),
    .st_o     (st),
    .trap_o   (trap_req_o)
  );

  fpu_exc_round_dec #(.SEL_W(RND_W)) u_round (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (st.rnd),
    .mode_o(round_mode_o)
  );

  assign rd_data_o = fsr_to_word(st, VERSION_ID);

  assert_cexc_loaded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && wr_kind_i == 2'd0) |=> (rd_data_o[4:0] == $past(flags)));

  assert_trap_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && wr_kind_i == 2'd0 && (flags & rd_data_o[27:23]) != '0) |=> trap_req_o);

  assert_full_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind_i == 2'd1) |=> (rd_data_o[11:10] == $past(wr_data_i[11:10])));
endmodule

// File: tb/fpu_exc_unit_tb_top.sv
module fpu_exc_unit_tb_top;
  localparam logic [2:0] VER = 3'd5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_done_i = 1'b0;
  logic [4:0]  fl = '0;
  logic [1:0]  wr_kind_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [3:0]  round_mode_o;
  logic        trap_req_o;

  always #5 clk_i = ~clk_i;

  fpu_exc_unit #(.VERSION_ID(VER), .TRAP_CODE(3'd1)) dut_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .op_done_i       (op_done_i),
    .flag_invalid_i  (fl[4]),
    .flag_overflow_i (fl[3]),
    .flag_underflow_i(fl[2]),
    .flag_divzero_i  (fl[1]),
    .flag_inexact_i  (fl[0]),
    .wr_kind_i       (wr_kind_i),
    .wr_data_i       (wr_data_i),
    .rd_data_o       (rd_data_o),
    .round_mode_o    (round_mode_o),
    .trap_req_o      (trap_req_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference model
  int m_cexc, m_aexc, m_fcc, m_ftt, m_tem, m_rnd;
  bit m_trap;
  string m_tag = "R1";

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cexc = 0; m_aexc = 0; m_fcc = 0; m_ftt = 0; m_tem = 0; m_rnd = 0;
      m_trap = 0; m_tag = "R1";
    end else begin
      m_trap = 0;
      if (wr_kind_i != 0) begin
        m_cexc = wr_data_i[4:0];
        m_aexc = wr_data_i[9:5];
        m_tem  = wr_data_i[27:23];
        m_rnd  = wr_data_i[31:30];
        if (wr_kind_i == 1) m_fcc = wr_data_i[11:10];
        if (wr_kind_i != 3) m_ftt = wr_data_i[16:14];
        m_tag = op_done_i ? "R12" : (wr_kind_i == 1 ? "R8" : (wr_kind_i == 2 ? "R9" : "R10"));
      end else if (op_done_i) begin
        m_cexc = fl;
        if ((fl & m_tem) != 0) begin
          m_ftt = 1; m_trap = 1; m_tag = "R4";
        end else begin
          m_aexc = m_aexc | fl; m_ftt = 0; m_tag = "R5";
        end
      end else begin
        m_tag = "R6";
      end
    end
  end

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = '0;
    w[4:0] = m_cexc[4:0]; w[9:5] = m_aexc[4:0]; w[11:10] = m_fcc[1:0];
    w[16:14] = m_ftt[2:0]; w[19:17] = VER; w[27:23] = m_tem[4:0];
    w[31:30] = m_rnd[1:0];
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(m_tag, rd_data_o, exp_word());
    chk("R7", {28'd0, round_mode_o}, 32'd1 << m_rnd);
    chk("R3", {31'd0, trap_req_o}, {31'd0, m_trap});
    chk("R11", {29'd0, rd_data_o[19:17]}, {29'd0, VER});
  endtask

  task automatic step(input bit d, input logic [4:0] f, input logic [1:0] k,
                      input logic [31:0] w);
    op_done_i = d; fl = f; wr_kind_i = k; wr_data_i = w;
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
  endtask

  function automatic logic [31:0] mk(input int rnd, input int tem, input int ftt,
                                     input int fcc, input int aexc, input int cexc);
    logic [31:0] w;
    w = '0;
    w[31:30] = rnd[1:0]; w[27:23] = tem[4:0]; w[16:14] = ftt[2:0];
    w[11:10] = fcc[1:0]; w[9:5] = aexc[4:0]; w[4:0] = cexc[4:0];
    return w;
  endfunction

  initial begin
    #1_500_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", rd_data_o, {12'd0, VER, 17'd0});
    chk("R1", {28'd0, round_mode_o}, 32'd1);
    chk("R1", {31'd0, trap_req_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare();

    // R7 rounding decode, R11 version bits written as ones
    for (int r = 0; r < 4; r++) step(0, 5'h00, 2'd1, mk(r, 0, 0, 0, 0, 0) | 32'h000E_0000);

    // R2/R5 single flags with mask clear
    for (int b = 0; b < 5; b++) begin
      step(1, 5'b1 << b, 2'd0, '0);
      chk("R2", {27'd0, rd_data_o[4:0]}, 32'd1 << b);
    end
    chk("R5", {27'd0, rd_data_o[9:5]}, 32'h1F);

    // R3/R4 enable invalid, clear accrued, then trap
    step(0, 5'h00, 2'd1, mk(0, 5'h10, 0, 2, 0, 0));
    step(1, 5'h11, 2'd0, '0);
    chk("R3", {31'd0, trap_req_o}, 32'd1);
    chk("R4", {27'd0, rd_data_o[9:5]}, 32'd0);
    chk("R3", {29'd0, rd_data_o[16:14]}, 32'd1);
    step(0, 5'h00, 2'd0, '0);
    chk("R3", {31'd0, trap_req_o}, 32'd0);

    // R6 flags without strobe
    step(0, 5'h1F, 2'd0, '0);
    chk("R6", {27'd0, rd_data_o[4:0]}, 32'h11);

    // R10 partial write keeps trap type and condition codes
    step(0, 5'h00, 2'd3, mk(2, 5'h01, 6, 1, 3, 4));
    chk("R10", {29'd0, rd_data_o[16:14]}, 32'd1);
    chk("R10", {30'd0, rd_data_o[11:10]}, 32'd2);
    // R9 keeps condition codes, loads trap type
    step(0, 5'h00, 2'd2, mk(1, 0, 5, 3, 0, 0));
    chk("R9", {30'd0, rd_data_o[11:10]}, 32'd2);
    chk("R9", {29'd0, rd_data_o[16:14]}, 32'd5);

    // R12 collision
    step(1, 5'h1F, 2'd1, mk(0, 5'h1F, 0, 0, 0, 0));
    chk("R12", {31'd0, trap_req_o}, 32'd0);
    step(1, 5'h1F, 2'd2, mk(0, 5'h1F, 0, 0, 0, 0));
    chk("R12", {31'd0, trap_req_o}, 32'd0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [1:0] k;
      sel = $urandom_range(0, 9);
      k = (sel < 2) ? 2'($urandom_range(1, 3)) : 2'd0;
      step(1'($urandom_range(0, 1)), 5'($urandom), k, $urandom);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule